// File: doc/BRIEF.md
# DMA Request and Channel Status Register Bank

This block is the small status and request register bank that sits beside a multi-channel DMA controller. Software reaches it over a simple memory-mapped read/write bus with a two-bit word index. It can raise a burst request on any of 16 request lines by writing ones. It can also read back which lines are requesting, which of 8 channels are enabled, and which channels carry a raw error interrupt before any masking.

Software request bits can only be set by a bus write, and only the channel engine clears them, by signalling that the transaction on that line has completed. Toward the channel engine, each line's request is the OR of the peripheral request wire and the software bit. A read of the request register returns the same merged view.

Channel enable flags are set by a one-cycle strobe from the configuration logic and cleared when the channel's transfer completes. Error flags are set by a one-cycle error pulse and cleared by a per-channel clear input. In every set/clear collision the set wins.

Top module: `dma_req_stat_regs`

## Requirements
- R1: With `rst_n` low at a rising clock edge, all software request bits, channel enable flags, error flags and `bus_rdata` become zero at that edge, whatever the other inputs do.
- R2: A bus write (`bus_sel`=1, `bus_we`=1) to index 0 sets each software request bit whose `bus_wdata` bit (15:0) is 1, at the clock edge. Data bits that are 0 leave their request bits unchanged.
- R3: A 1 on `line_done[i]` at a clock edge clears software request bit i at that edge.
- R4: If a write sets bit i and `line_done[i]` is 1 in the same cycle, the bit ends up set.
- R5: `line_req` is, combinationally, `periph_req` OR the software request bits.
- R6: A bus read (`bus_sel`=1, `bus_we`=0) of index 0 loads `bus_rdata` at the next clock edge with `periph_req | soft_requests` in bits 15:0 and zero in bits 31:16. `bus_rdata` holds its value in cycles without a read.
- R7: `ch_en_strobe[c]` sets enable flag c and `ch_xfer_done[c]` clears it, both at the clock edge. If both are 1 together, the flag ends up set. `ch_enabled` shows the flags.
- R8: `ch_err_pulse[c]` sets error flag c and `ch_err_clr[c]` clears it, both at the clock edge. If both are 1 together, the flag ends up set. `ch_err_raw` shows the flags.
- R9: A read of index 1 returns the enable flags, and a read of index 2 returns the error flags, both in bits 7:0. A read of index 3 returns zero. All unused bits read zero. The value appears at the next edge, as in R6.
- R10: Writes to indexes 1, 2 and 3, and write data bits 31:16 at index 0, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 requests, 1 enables, 2 errors, 3 spare |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| periph_req | input | 16 | Peripheral request lines |
| line_done | input | 16 | Per-line transaction complete pulse |
| line_req | output | 16 | Merged request toward the channel engine |
| ch_en_strobe | input | 8 | Per-channel enable set strobe |
| ch_xfer_done | input | 8 | Per-channel transfer complete pulse |
| ch_err_pulse | input | 8 | Per-channel error set pulse |
| ch_err_clr | input | 8 | Per-channel error clear |
| ch_enabled | output | 8 | Channel enable flags |
| ch_err_raw | output | 8 | Raw error flags |

## Verification
The directed patterns each isolate one behaviour. Writes mixing one and zero bits separate set-only behaviour from a plain overwrite. Completion pulses landing with and without a same-cycle write separate set priority from clear priority. Peripheral lines driven while the software bits are idle or already set separate the OR merge from either source alone. Writes of all ones to the read-only indexes, and to the upper half of index 0, expose any decode leak. A long random phase then mixes every input at once against a behavioural model, so that interactions the directed cases miss still show up as miscompares on the four outputs.

// File: rtl/dmars_pkg.sv
package dmars_pkg;
    localparam int REG_IDX_W = 2;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_SWREQ  = 2'd0,
        REG_CHEN   = 2'd1,
        REG_ERRRAW = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dmars_setclr_bank.sv
module dmars_setclr_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } bank_t;

    bank_t        st_d, st_q;
    logic [W-1:0] bit_nxt;

    // Set has priority over clear on every bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_nxt[i] = set_i[i] | (st_q.bits[i] & ~clr_i[i]);
    end

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.bits = '0;
        end else begin
            st_d.bits = bit_nxt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_o = st_q.bits;
endmodule

// File: rtl/dmars_read_port.sv
module dmars_read_port
    import dmars_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_CH    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  reg_sel_e             rd_sel,
    input  logic [NUM_LINES-1:0] req_view,
    input  logic [NUM_CH-1:0]    en_view,
    input  logic [NUM_CH-1:0]    err_view,
    output logic [DATA_W-1:0]    rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t               st_d, st_q;
    logic [DATA_W-1:0] mux;

    always_comb begin
        mux = '0;
        unique case (rd_sel)
            REG_SWREQ:  mux[NUM_LINES-1:0] = req_view;
            REG_CHEN:   mux[NUM_CH-1:0]    = en_view;
            REG_ERRRAW: mux[NUM_CH-1:0]    = err_view;
            default:    mux                = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.data = '0;
        end else if (rd_en) begin
            st_d.data = mux;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata = st_q.data;

    // Unused upper bits never carry data (R9)
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:NUM_LINES] == '0);
endmodule

// File: rtl/dma_req_stat_regs.sv
module dma_req_stat_regs
    import dmars_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_CH    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [REG_IDX_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] periph_req,
    input  logic [NUM_LINES-1:0] line_done,
    output logic [NUM_LINES-1:0] line_req,
    input  logic [NUM_CH-1:0]    ch_en_strobe,
    input  logic [NUM_CH-1:0]    ch_xfer_done,
    input  logic [NUM_CH-1:0]    ch_err_pulse,
    input  logic [NUM_CH-1:0]    ch_err_clr,
    output logic [NUM_CH-1:0]    ch_enabled,
    output logic [NUM_CH-1:0]    ch_err_raw
);
    reg_sel_e             sel;
    logic                 wr_hit;
    logic [NUM_LINES-1:0] sw_set;
    logic [NUM_LINES-1:0] sw_q;
    logic                 rd_en;

    assign sel    = reg_sel_e'(bus_addr);
    assign wr_hit = bus_sel && bus_we && (sel == REG_SWREQ);
    assign sw_set = wr_hit ? bus_wdata[NUM_LINES-1:0] : '0;
    assign rd_en  = bus_sel && !bus_we;

    dmars_setclr_bank #(.W(NUM_LINES)) u_swreq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sw_set),
        .clr_i (line_done),
        .q_o   (sw_q)
    );

    dmars_setclr_bank #(.W(NUM_CH)) u_chen (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ch_en_strobe),
        .clr_i (ch_xfer_done),
        .q_o   (ch_enabled)
    );

    dmars_setclr_bank #(.W(NUM_CH)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ch_err_pulse),
        .clr_i (ch_err_clr),
        .q_o   (ch_err_raw)
    );

    assign line_req = periph_req | sw_q;

    dmars_read_port #(
        .NUM_LINES (NUM_LINES),
        .NUM_CH    (NUM_CH),
        .DATA_W    (DATA_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_sel   (sel),
        .req_view (line_req),
        .en_view  (ch_enabled),
        .err_view (ch_err_raw),
        .rdata    (bus_rdata)
    );

    // R1: reset empties every flag
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (sw_q == '0) && (ch_enabled == '0) && (ch_err_raw == '0));

    // R3: completion without a set clears the bit
    p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_done & ~sw_set) != '0) |=> ((sw_q & $past(line_done & ~sw_set)) == '0));

    // R4: set wins over same-cycle completion
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_done & sw_set) != '0) |=>
            ((sw_q & $past(line_done & sw_set)) == $past(line_done & sw_set)));

    // R7: enable strobe wins over transfer completion
    p_en_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_en_strobe & ch_xfer_done) != '0) |=>
            ((ch_enabled & $past(ch_en_strobe & ch_xfer_done)) == $past(ch_en_strobe & ch_xfer_done)));

    // R8: error pulse wins over clear
    p_err_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_err_pulse & ch_err_clr) != '0) |=>
            ((ch_err_raw & $past(ch_err_pulse & ch_err_clr)) == $past(ch_err_pulse & ch_err_clr)));

    // R10: writes elsewhere leave the requests untouched
    p_other_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && (bus_addr != 2'd0) && (line_done == '0)) |=> $stable(sw_q));
endmodule

// File: tb/dma_req_stat_regs_bench.sv
module dma_req_stat_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] periph_req = '0;
    logic [15:0] line_done = '0;
    logic [15:0] line_req;
    logic [7:0]  ch_en_strobe = '0;
    logic [7:0]  ch_xfer_done = '0;
    logic [7:0]  ch_err_pulse = '0;
    logic [7:0]  ch_err_clr = '0;
    logic [7:0]  ch_enabled;
    logic [7:0]  ch_err_raw;

    int    vectors = 0;
    int    miscmp = 0;
    bit    finished = 1'b0;
    string phase = "R1";

    // behavioural reference state
    logic [15:0] m_soft = '0;
    logic [7:0]  m_en = '0;
    logic [7:0]  m_err = '0;
    logic [31:0] m_rd = '0;

    always #4 clk = ~clk;

    dma_req_stat_regs u_dma_req_stat_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .periph_req   (periph_req),
        .line_done    (line_done),
        .line_req     (line_req),
        .ch_en_strobe (ch_en_strobe),
        .ch_xfer_done (ch_xfer_done),
        .ch_err_pulse (ch_err_pulse),
        .ch_err_clr   (ch_err_clr),
        .ch_enabled   (ch_enabled),
        .ch_err_raw   (ch_err_raw)
    );

    // Reference model: inputs change only at falling edges.
    always @(posedge clk) begin
        logic [15:0] old_soft;
        logic [7:0]  old_en;
        logic [7:0]  old_err;
        logic [15:0] wr;
        old_soft = m_soft;
        old_en   = m_en;
        old_err  = m_err;
        if (!rst_n) begin
            m_soft = '0;
            m_en   = '0;
            m_err  = '0;
            m_rd   = '0;
        end else begin
            wr = (bus_sel && bus_we && bus_addr == 2'd0) ? bus_wdata[15:0] : 16'h0;
            for (int i = 0; i < 16; i++) begin
                if (wr[i]) m_soft[i] = 1'b1;
                else if (line_done[i]) m_soft[i] = 1'b0;
            end
            for (int c = 0; c < 8; c++) begin
                if (ch_en_strobe[c]) m_en[c] = 1'b1;
                else if (ch_xfer_done[c]) m_en[c] = 1'b0;
                if (ch_err_pulse[c]) m_err[c] = 1'b1;
                else if (ch_err_clr[c]) m_err[c] = 1'b0;
            end
            if (bus_sel && !bus_we) begin
                case (bus_addr)
                    2'd0:    m_rd = {16'h0, periph_req | old_soft};
                    2'd1:    m_rd = {24'h0, old_en};
                    2'd2:    m_rd = {24'h0, old_err};
                    default: m_rd = 32'h0;
                endcase
            end
        end
    end

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s (phase %s) actual=%h expected=%h", tag, phase, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cmp("R5 line_req", {16'h0, line_req}, {16'h0, periph_req | m_soft});
        cmp("R7 ch_enabled", {24'h0, ch_enabled}, {24'h0, m_en});
        cmp("R8 ch_err_raw", {24'h0, ch_err_raw}, {24'h0, m_err});
        cmp("R6/R9 bus_rdata", bus_rdata, m_rd);
    endtask

    task automatic idle();
        bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        line_done = 0; ch_en_strobe = 0; ch_xfer_done = 0;
        ch_err_pulse = 0; ch_err_clr = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [1:0] a);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        tick();
        bus_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscmp++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        // R1: reset dominates busy inputs
        phase = "R1";
        bus_sel = 1; bus_we = 1; bus_addr = 0; bus_wdata = 32'hFFFF_FFFF;
        ch_en_strobe = 8'hFF; ch_err_pulse = 8'hFF;
        repeat (3) tick();
        idle();
        rst_n = 1;
        tick();
        cmp("R1 rdata after reset", bus_rdata, 32'h0);
        cmp("R1 enables after reset", {24'h0, ch_enabled}, 32'h0);

        // R2: set-only write behaviour
        phase = "R2";
        wr(2'd0, 32'h0000_00A5);
        wr(2'd0, 32'h0000_0000);
        rd(2'd0);
        cmp("R2 readback", bus_rdata, 32'h0000_00A5);

        // R3: completion clears
        phase = "R3";
        line_done = 16'h0005; tick(); line_done = 0;
        rd(2'd0);
        cmp("R3 readback", bus_rdata, 32'h0000_00A0);

        // R4: same-cycle set and completion
        phase = "R4";
        line_done = 16'h0101;
        wr(2'd0, 32'h0000_0001);
        line_done = 0;
        cmp("R4 line_req", {16'h0, line_req}, 32'h0000_00A1);

        // R5: merge of peripheral and software requests
        phase = "R5";
        periph_req = 16'h8000; tick();
        periph_req = 16'h00A1; tick();
        cmp("R5 overlap", {16'h0, line_req}, 32'h0000_00A1);
        periph_req = 16'h0F00; rd(2'd0);
        cmp("R5 merged readback", bus_rdata, 32'h0000_0FA1);
        periph_req = 0;

        // R6: upper write bits ignored, upper read bits zero, hold without read
        phase = "R6";
        wr(2'd0, 32'hFFFF_0000);
        rd(2'd0);
        cmp("R6 upper zero", bus_rdata, 32'h0000_00A1);
        periph_req = 16'h0002; tick(); tick();
        cmp("R6 hold", bus_rdata, 32'h0000_00A1);
        periph_req = 0;

        // R7: enable set, clear, collision
        phase = "R7";
        ch_en_strobe = 8'h3C; tick(); ch_en_strobe = 0;
        ch_xfer_done = 8'h0C; tick(); ch_xfer_done = 0;
        ch_en_strobe = 8'h81; ch_xfer_done = 8'h81; tick(); idle();
        cmp("R7 flags", {24'h0, ch_enabled}, 32'h0000_00B1);

        // R8: error set, clear, collision
        phase = "R8";
        ch_err_pulse = 8'hF0; tick(); ch_err_pulse = 0;
        ch_err_clr = 8'h30; tick(); ch_err_clr = 0;
        ch_err_pulse = 8'h02; ch_err_clr = 8'h82; tick(); idle();
        cmp("R8 flags", {24'h0, ch_err_raw}, 32'h0000_0042);

        // R9: other read indexes
        phase = "R9";
        rd(2'd1); cmp("R9 enables read", bus_rdata, 32'h0000_00B1);
        rd(2'd2); cmp("R9 errors read", bus_rdata, 32'h0000_0042);
        rd(2'd3); cmp("R9 spare read", bus_rdata, 32'h0);

        // R10: writes to read-only and spare indexes
        phase = "R10";
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0000_0000);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd0); cmp("R10 requests intact", bus_rdata, 32'h0000_00A1);
        rd(2'd1); cmp("R10 enables intact", bus_rdata, 32'h0000_00B1);

        // Mixed random traffic against the model (R2..R10)
        phase = "random";
        for (int n = 0; n < 3000; n++) begin
            bus_sel      = ($urandom_range(0, 2) == 0);
            bus_we       = $urandom_range(0, 1);
            bus_addr     = 2'($urandom_range(0, 3));
            bus_wdata    = $urandom;
            periph_req   = 16'($urandom) & 16'($urandom);
            line_done    = 16'($urandom) & 16'($urandom) & 16'($urandom);
            ch_en_strobe = 8'($urandom) & 8'($urandom);
            ch_xfer_done = 8'($urandom) & 8'($urandom);
            ch_err_pulse = 8'($urandom) & 8'($urandom) & 8'($urandom);
            ch_err_clr   = 8'($urandom) & 8'($urandom);
            tick();
        end
        idle();
        periph_req = 0;
        tick();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule